// File: doc/BRIEF.md
# Coprocessor Escape Synchronizer

This block watches a host instruction stream one two-byte instruction at a time and decides who acts on each one. Instructions without the escape tag in the first byte stay with the host and pass through untouched. Tagged instructions are forwarded to a floating-point coprocessor as a one-cycle strobe that carries the decoded fields. The top two bits of the second byte are a mode field, and they set how the host continues after the hand-off.

A register-only escape needs no memory access. It is forwarded, and the host keeps issuing its own instructions while the coprocessor works. Any other mode value needs memory. The coprocessor cannot address memory itself, so the host resolves the address and the block opens a single data-transfer window for it. The host stays stalled until the coprocessor drops its busy line, and then the window closes.

A new escape that arrives while the coprocessor is still busy is held, with the host stalled, until busy falls. An error line from the coprocessor sets a sticky flag. Only a dedicated clear input resets that flag.

Top module: `escape_sync`

## Requirements
- R1: After reset, `fwd_valid`, `mem_win`, `err_flag` and `fwd_addp` are 0. `host_stall` is 0 while no escape is presented.
- R2: An instruction is an escape when `ins_b0[7:3]` equals 11011. An escape is taken in a cycle where `ins_valid` is high, `cop_busy` is low and no window is open. A taken escape raises `fwd_valid` for exactly one cycle, starting the next cycle. A non-escape never raises `fwd_valid`, and it never stalls the host outside a window.
- R3: When `ins_b1[7:6]` is 11, the escape is register-only. It is forwarded with `fwd_mem` = 0, no window opens, and `host_stall` stays low afterwards.
- R4: When `ins_b1[7:6]` is not 11, the escape needs memory. It is forwarded with `fwd_mem` = 1, and `mem_win` rises in the same cycle as `fwd_valid`. `host_stall` is high for as long as `mem_win` is high.
- R5: An open window stays open in every cycle after a cycle in which `cop_busy` was sampled high. It closes in the cycle after the first cycle in which `cop_busy` is sampled low.
- R6: An escape presented while `cop_busy` is high and no window is open drives `host_stall` high in that same cycle and is not forwarded. It is taken in the first cycle in which busy is low.
- R7: With each forward strobe, `fwd_grp` = `ins_b0[2:0]`, `fwd_mod` = `ins_b1[7:6]`, `fwd_mid` = `ins_b1[5:3]` and `fwd_rm` = `ins_b1[2:0]` of the taken instruction.
- R8: `fwd_addp` is 1 with a strobe exactly when group is 110, mode is 11 and middle field is 000. This is the add-and-pop operation, and its destination register index is `fwd_rm`.
- R9: `cop_err` high sets `err_flag` in the next cycle. `err_clr` with `cop_err` low clears it in the next cycle. When both are high, the flag is set.
- R10: While a window is open, any presented escape holds `host_stall` high and is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction pair presented |
| ins_b0 | input | 8 | Opcode byte |
| ins_b1 | input | 8 | Addressing-mode byte |
| cop_busy | input | 1 | Coprocessor busy (low means ready) |
| cop_err | input | 1 | Coprocessor error |
| err_clr | input | 1 | Clears the sticky error flag |
| fwd_valid | output | 1 | One-cycle forward strobe |
| fwd_grp | output | 3 | Operation group from opcode byte |
| fwd_mod | output | 2 | Mode field |
| fwd_mid | output | 3 | Middle field of mode byte |
| fwd_rm | output | 3 | Register or memory field |
| fwd_mem | output | 1 | Forwarded escape needs memory |
| fwd_addp | output | 1 | Forwarded escape is add-and-pop |
| host_stall | output | 1 | Host must not advance |
| mem_win | output | 1 | Data-transfer window open |
| err_flag | output | 1 | Sticky coprocessor error |

## Verification
The assertions assume the host holds a stalled escape steady until it is taken. They also assume the coprocessor raises busy only in response to a forward, and that it lowers busy only after one transfer. Under these assumptions the window-hold and window-close properties describe a single transfer.

The sweeps stay within these assumptions. Each instruction is presented for one cycle while the coprocessor is idle. Busy is raised only while a window it caused is open, and it is dropped after a chosen number of cycles. Held escapes are driven in separate directed phases, and busy is released there before any new instruction is presented.

// File: rtl/escape_sync.sv
module escape_sync #(
  parameter logic [4:0] ESC_TAG  = 5'b11011,
  parameter logic [1:0] REG_MOD  = 2'b11,
  parameter logic [2:0] ADDP_GRP = 3'b110,
  parameter logic [2:0] ADDP_MID = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ins_valid,
  input  logic [7:0] ins_b0,
  input  logic [7:0] ins_b1,
  input  logic       cop_busy,
  input  logic       cop_err,
  input  logic       err_clr,
  output logic       fwd_valid,
  output logic [2:0] fwd_grp,
  output logic [1:0] fwd_mod,
  output logic [2:0] fwd_mid,
  output logic [2:0] fwd_rm,
  output logic       fwd_mem,
  output logic       fwd_addp,
  output logic       host_stall,
  output logic       mem_win,
  output logic       err_flag
);

  logic is_esc, is_reg, take, win;

  assign is_esc     = ins_b0[7:3] == ESC_TAG;
  assign is_reg     = ins_b1[7:6] == REG_MOD;
  assign take       = ins_valid & is_esc & ~cop_busy & ~win;
  assign host_stall = win | (ins_valid & is_esc & cop_busy);
  assign mem_win    = win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win       <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_grp   <= '0;
      fwd_mod   <= '0;
      fwd_mid   <= '0;
      fwd_rm    <= '0;
      fwd_mem   <= 1'b0;
      fwd_addp  <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      fwd_valid <= take;
      if (take) begin
        fwd_grp  <= ins_b0[2:0];
        fwd_mod  <= ins_b1[7:6];
        fwd_mid  <= ins_b1[5:3];
        fwd_rm   <= ins_b1[2:0];
        fwd_mem  <= ~is_reg;
        fwd_addp <= is_reg & (ins_b0[2:0] == ADDP_GRP) & (ins_b1[5:3] == ADDP_MID);
      end
      if (take && !is_reg)
        win <= 1'b1;
      else if (win && !cop_busy)
        win <= 1'b0;
      err_flag <= cop_err | (err_flag & ~err_clr);
    end
  end

endmodule

// File: rtl/escape_sync_chk.sv
module escape_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic [7:0] ins_b0,
  input logic [7:0] ins_b1,
  input logic       cop_busy,
  input logic       cop_err,
  input logic       err_clr,
  input logic       fwd_valid,
  input logic [2:0] fwd_grp,
  input logic [1:0] fwd_mod,
  input logic [2:0] fwd_mid,
  input logic [2:0] fwd_rm,
  input logic       fwd_mem,
  input logic       fwd_addp,
  input logic       host_stall,
  input logic       mem_win,
  input logic       err_flag
);
  logic esc;
  assign esc = ins_b0[7:3] == 5'b11011;

  p_fwd_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && esc && !cop_busy && !mem_win |=> fwd_valid);
  p_fwd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(ins_valid && esc));
  p_reg_nowin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_mod == 2'b11 |-> !mem_win && !fwd_mem);
  p_mem_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_mod != 2'b11 |-> mem_win);
  p_win_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win |-> host_stall);
  p_win_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win && cop_busy |=> mem_win);
  p_win_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win && !cop_busy |=> !mem_win);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && esc && cop_busy |-> host_stall);
  p_addp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_addp |-> fwd_grp == 3'b110 && fwd_mod == 2'b11 && fwd_mid == 3'b000);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cop_err |=> err_flag);
  p_err_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !cop_err |=> !err_flag);
  p_win_nofwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win |=> !fwd_valid);
endmodule

bind escape_sync escape_sync_chk i_chk (.*);

// File: tb/test_escape_sync.sv
`timescale 1ns/1ps
module test_escape_sync;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, cop_busy = 0, cop_err = 0, err_clr = 0;
  logic [7:0] ins_b0 = 0, ins_b1 = 0;
  logic fwd_valid, fwd_mem, fwd_addp, host_stall, mem_win, err_flag;
  logic [2:0] fwd_grp, fwd_mid, fwd_rm;
  logic [1:0] fwd_mod;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  escape_sync i_escape_sync (.*);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (b0=%h b1=%h)", r, act, exp, ins_b0, ins_b1);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_one(input logic [7:0] b0, input logic [7:0] b1, input int blen);
    bit esc, regm, addp;
    esc  = b0[7:3] == 5'b11011;
    regm = b1[7:6] == 2'b11;
    addp = esc && regm && b0[2:0] == 3'b110 && b1[5:3] == 3'b000;
    @(negedge clk);
    ins_valid = 1; ins_b0 = b0; ins_b1 = b1; cop_busy = 0;
    #1 chk("R2 stall on take", host_stall, 0);
    @(negedge clk);
    ins_valid = 0;
    chk("R2 fwd_valid", fwd_valid, esc);
    if (esc) begin
      chk("R7 grp", fwd_grp, b0[2:0]);
      chk("R7 mod", fwd_mod, b1[7:6]);
      chk("R7 mid", fwd_mid, b1[5:3]);
      chk("R7 rm", fwd_rm, b1[2:0]);
      chk("R8 addp", fwd_addp, addp);
      chk("R3 fwd_mem", fwd_mem, !regm);
    end
    chk("R4 mem_win open", mem_win, esc && !regm);
    chk("R4 stall in window", host_stall, esc && !regm);
    if (esc && !regm) begin
      for (int i = 0; i < blen; i++) begin
        cop_busy = 1;
        @(negedge clk);
        chk("R5 window held", mem_win, 1);
        chk("R2 single strobe", fwd_valid, 0);
      end
      cop_busy = 0;
      @(negedge clk);
      chk("R5 window closed", mem_win, 0);
      chk("R5 stall released", host_stall, 0);
    end else begin
      @(negedge clk);
      chk("R3 no stall after", host_stall, 0);
    end
    chk("R2 strobe one cycle", fwd_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #5 rst_n = 1;
    @(negedge clk);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 mem_win", mem_win, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 fwd_addp", fwd_addp, 0);
    chk("R1 host_stall", host_stall, 0);

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7)
        run_one(a[7:0], b[7:0], b % 3);

    // R6: escape held while busy, non-escape not stalled
    @(negedge clk);
    cop_busy = 1; ins_valid = 1; ins_b0 = 8'h90; ins_b1 = 8'h00;
    #1 chk("R6 non-escape busy no stall", host_stall, 0);
    @(negedge clk);
    ins_b0 = 8'hDE; ins_b1 = 8'hC1;
    chk("R2 non-escape not forwarded", fwd_valid, 0);
    #1 chk("R6 escape stalls while busy", host_stall, 1);
    @(negedge clk);
    chk("R6 not forwarded while busy", fwd_valid, 0);
    cop_busy = 0;
    #1 chk("R6 stall drops when ready", host_stall, 0);
    @(negedge clk);
    ins_valid = 0;
    chk("R6 taken after busy", fwd_valid, 1);
    chk("R8 add-and-pop DE C1", fwd_addp, 1);
    chk("R8 destination", fwd_rm, 1);

    // R10: escape during window
    @(negedge clk);
    ins_valid = 1; ins_b0 = 8'hDD; ins_b1 = 8'h05;
    @(negedge clk);
    chk("R4 window opened", mem_win, 1);
    cop_busy = 1; ins_b0 = 8'hD8; ins_b1 = 8'hC2;
    #1 chk("R10 stall during window", host_stall, 1);
    @(negedge clk);
    chk("R10 not forwarded in window", fwd_valid, 0);
    cop_busy = 0;
    #1 chk("R10 still stalled", host_stall, 1);
    @(negedge clk);
    chk("R10 not forwarded at close", fwd_valid, 0);
    chk("R5 closed", mem_win, 0);
    #1 chk("R10 taken after close", host_stall, 0);
    @(negedge clk);
    ins_valid = 0;
    chk("R10 forwarded after close", fwd_valid, 1);
    chk("R7 rm after close", fwd_rm, 2);

    // R9: sticky error
    @(negedge clk);
    cop_err = 1;
    @(negedge clk);
    cop_err = 0;
    chk("R9 set", err_flag, 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", err_flag, 1);
    err_clr = 1; cop_err = 1;
    @(negedge clk);
    cop_err = 0;
    chk("R9 set wins over clear", err_flag, 1);
    @(negedge clk);
    err_clr = 0;
    chk("R9 cleared", err_flag, 0);
    @(negedge clk);
    chk("R9 stays clear", err_flag, 0);

    done = 1;
    summary();
  end
endmodule